// File: doc/BRIEF.md
# Descriptor-Aware Bit-String Operator

This unit executes bit-string primitives on variables that carry a length descriptor and a position pointer. One operand record is accepted per handshake. It holds X data, X length, X pointer, Y data, Y length and an operation select. The unit forms the result word, its length descriptor, an overflow flag and an updated pointer for the source operand, all in one combinational step. It places them in an output register so that they can be written back.

Two primitives share the datapath. A join places the X string above the Y string and sums the lengths. A slice takes a bit field out of X, starting at the pointer carried with X. The field length is given in the Y length slot, and the result is right-aligned. A result that would not fit the word width is saturated, and the overflow flag is raised. The input side takes a new record every cycle while the result side is drained. A result that has not been taken is held.

Top module: `strops_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 at the next clock edge and stays 0. After reset, `in_ready` is 1 until a result is pending.
- R2: With `in_op` = 0 (join), `out_data` holds Y in bits [ly-1:0] and X directly above it. X data bits at or above `x_len`, and Y data bits at or above `y_len`, have no effect.
- R3: For a join, `out_len` = `x_len` + `y_len`. For example, a 12-bit X joined with an 8-bit Y gives length 20 and data {X, Y}.
- R4: For a join whose summed length exceeds W (64), `out_len` = W and `out_ovf` = 1. The low W bits of the joined string are kept. A sum of exactly W gives `out_ovf` = 0.
- R5: With `in_op` = 1 (slice), `out_data` holds X bits [p+n-1:p] right-aligned, where p = `x_ptr` and n = `y_len`. In that case `out_len` = n and `out_ovf` = 0.
- R6: For a slice with p + n > W, `out_len` = W - p and `out_ovf` = 1. A value of p at or above W is treated as W, which gives length 0.
- R7: `out_src_ptr` returns the X pointer after the primitive. For a slice it is the clamped p plus `out_len`. For a join it equals `x_ptr` unchanged.
- R8: Whenever `out_valid` is 1, `out_len` <= W, and every `out_data` bit at or above `out_len` is 0.
- R9: An input length above W is treated as W, in both operations.
- R10: A record accepted at a clock edge (`in_valid` and `in_ready` both 1) appears on the outputs after that same edge. `in_ready` = !`out_valid` | `out_ready`, so records can be accepted on consecutive cycles. While `out_valid` is 1 and `out_ready` is 0, all outputs are held and `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand record present |
| in_ready | output | 1 | Unit can take a record this cycle |
| in_op | input | 1 | 0 = join, 1 = slice |
| x_data | input | 64 | X string data |
| x_len | input | 7 | X length descriptor |
| x_ptr | input | 7 | X pointer descriptor (slice start bit) |
| y_data | input | 64 | Y string data (unused by slice) |
| y_len | input | 7 | Y length; slice field length |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 64 | Result string, zero above its length |
| out_len | output | 7 | Result length descriptor |
| out_ovf | output | 1 | Result was saturated to the word width |
| out_src_ptr | output | 7 | Updated X pointer descriptor |

## Verification
A record accepted at clock edge k is due on the outputs just after edge k. The bench tags each expected item with that edge number. At every falling edge, the monitor requires `out_valid` to equal "the oldest pending item's due edge has passed". It compares all result fields only in the cycle a transfer happens. Under backpressure, each stalled cycle is checked for unchanged outputs and for `in_ready` low. The due-edge rule therefore covers both the one-cycle case and the held case.

// File: rtl/strops_pkg.sv
// Shared types for the bit-string operator.
// Assumes: operation select is a single bit at the block edge.
package strops_pkg;
    typedef enum logic {
        OP_JOIN  = 1'b0,
        OP_SLICE = 1'b1
    } strop_e;
endpackage

// File: rtl/strops_lenmask.sv
// Builds a thermometer mask with the low `len` bits set.
// Assumes: len <= W; a len of W or more sets every bit.
module strops_lenmask #(
    parameter int W  = 64,
    parameter int LW = $clog2(W + 1)
) (
    input  logic [LW-1:0] len,
    output logic [W-1:0]  mask
);
    // one comparator per bit position
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign mask[i] = (len > LW'(i));
    end
endmodule

// File: rtl/strops_join.sv
// Join primitive: places X above Y and sums the length descriptors.
// Assumes: x and y are already masked to their lengths; lengths <= W.
module strops_join #(
    parameter int W  = 64,
    parameter int LW = $clog2(W + 1)
) (
    input  logic [W-1:0]  x,
    input  logic [LW-1:0] lx,
    input  logic [W-1:0]  y,
    input  logic [LW-1:0] ly,
    output logic [W-1:0]  data,
    output logic [LW-1:0] len,
    output logic          ovf
);
    logic [2*W-1:0] wide;
    logic [LW:0]    sum;

    // data and length computed side by side
    always_comb begin
        wide = ({{W{1'b0}}, x} << ly) | {{W{1'b0}}, y};
        sum  = {1'b0, lx} + {1'b0, ly};
        ovf  = (sum > (LW+1)'(W));
        len  = ovf ? LW'(W) : sum[LW-1:0];
        data = wide[W-1:0];
    end
endmodule

// File: rtl/strops_slice.sv
// Slice primitive: extracts n bits of X starting at pointer p, right-aligned.
// Assumes: x is masked to its length; n <= W. p may exceed W and is clamped.
module strops_slice #(
    parameter int W  = 64,
    parameter int LW = $clog2(W + 1)
) (
    input  logic [W-1:0]  x,
    input  logic [LW-1:0] ptr,
    input  logic [LW-1:0] n,
    output logic [W-1:0]  data,
    output logic [LW-1:0] len,
    output logic          ovf,
    output logic [LW-1:0] next_ptr
);
    logic [LW-1:0] start;
    logic [LW-1:0] avail;
    logic [W-1:0]  fmask;

    strops_lenmask #(.W(W), .LW(LW)) u_fmask (.len(len), .mask(fmask));

    // clamp the start, clip the field to the room left in the word
    always_comb begin
        start    = (ptr > LW'(W)) ? LW'(W) : ptr;
        avail    = LW'(W) - start;
        ovf      = (n > avail);
        len      = ovf ? avail : n;
        data     = (x >> start) & fmask;
        next_ptr = start + len;
    end
endmodule

// File: rtl/strops_unit.sv
// Descriptor-aware bit-string operator, top level.
// Latches one operand record per handshake and computes result data,
// length, overflow and the updated X pointer in a single step.
// Assumes: one-entry output register; in_ready follows out_ready combinationally.
module strops_unit #(
    parameter int W  = 64,
    parameter int LW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          in_op,
    input  logic [W-1:0]  x_data,
    input  logic [LW-1:0] x_len,
    input  logic [LW-1:0] x_ptr,
    input  logic [W-1:0]  y_data,
    input  logic [LW-1:0] y_len,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [W-1:0]  out_data,
    output logic [LW-1:0] out_len,
    output logic          out_ovf,
    output logic [LW-1:0] out_src_ptr
);
    import strops_pkg::*;

    logic [LW-1:0] lx_c, ly_c;
    logic [W-1:0]  xmask, ymask, xm, ym;
    logic [W-1:0]  j_data, s_data, r_data;
    logic [LW-1:0] j_len, s_len, s_ptr, r_len, r_ptr;
    logic          j_ovf, s_ovf, r_ovf;
    logic          take;
    strop_e        op;

    // clamp descriptors to the word width and decode the operation
    always_comb begin
        lx_c = (x_len > LW'(W)) ? LW'(W) : x_len;
        ly_c = (y_len > LW'(W)) ? LW'(W) : y_len;
        op   = strop_e'(in_op);
        xm   = x_data & xmask;
        ym   = y_data & ymask;
    end

    strops_lenmask #(.W(W), .LW(LW)) u_xmask (.len(lx_c), .mask(xmask));
    strops_lenmask #(.W(W), .LW(LW)) u_ymask (.len(ly_c), .mask(ymask));

    strops_join #(.W(W), .LW(LW)) u_join (
        .x(xm), .lx(lx_c), .y(ym), .ly(ly_c),
        .data(j_data), .len(j_len), .ovf(j_ovf)
    );

    strops_slice #(.W(W), .LW(LW)) u_slice (
        .x(xm), .ptr(x_ptr), .n(ly_c),
        .data(s_data), .len(s_len), .ovf(s_ovf), .next_ptr(s_ptr)
    );

    // pick the primitive's result and its pointer update
    always_comb begin
        if (op == OP_SLICE) begin
            r_data = s_data; r_len = s_len; r_ovf = s_ovf; r_ptr = s_ptr;
        end else begin
            r_data = j_data; r_len = j_len; r_ovf = j_ovf; r_ptr = x_ptr;
        end
    end

    assign in_ready = !out_valid || out_ready;
    assign take     = in_valid && in_ready;

    // output register: load on accept, clear valid when drained
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_data    <= '0;
            out_len     <= '0;
            out_ovf     <= 1'b0;
            out_src_ptr <= '0;
        end else if (take) begin
            out_valid   <= 1'b1;
            out_data    <= r_data;
            out_len     <= r_len;
            out_ovf     <= r_ovf;
            out_src_ptr <= r_ptr;
        end else if (out_ready) begin
            out_valid   <= 1'b0;
        end
    end

    logic [W-1:0] omask;
    strops_lenmask #(.W(W), .LW(LW)) u_omask (.len(out_len), .mask(omask));

    // R1
    reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

    // R10
    accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
        $stable(out_len) && $stable(out_ovf) && $stable(out_src_ptr)));

    // R8
    len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_len <= LW'(W)));

    // R8
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_data & ~omask) == '0));
endmodule

// File: tb/strops_unit_tb_top.sv
module strops_unit_tb_top;
    localparam int W  = 64;
    localparam int LW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic          in_op = 1'b0;
    logic [W-1:0]  x_data = '0;
    logic [LW-1:0] x_len = '0;
    logic [LW-1:0] x_ptr = '0;
    logic [W-1:0]  y_data = '0;
    logic [LW-1:0] y_len = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [W-1:0]  out_data;
    logic [LW-1:0] out_len;
    logic          out_ovf;
    logic [LW-1:0] out_src_ptr;

    always #2.5 clk = ~clk;

    strops_unit #(.W(W), .LW(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .x_data(x_data), .x_len(x_len), .x_ptr(x_ptr),
        .y_data(y_data), .y_len(y_len), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_len(out_len),
        .out_ovf(out_ovf), .out_src_ptr(out_src_ptr)
    );

    typedef struct {
        logic [W-1:0]  d;
        logic [LW-1:0] l;
        logic          o;
        logic [LW-1:0] p;
        longint        e;
        string         tag;
    } exp_t;

    exp_t   sb[$];
    int     n_tests = 0;
    int     n_fail  = 0;
    longint edge_cnt = 0;
    int     rmode = 0;
    bit     done = 0;

    always @(posedge clk) edge_cnt++;

    // consumer ready pattern, changed away from the edge
    always @(posedge clk) begin
        #1;
        out_ready = (rmode == 0) ? 1'b1 : ((edge_cnt % 3) != 0);
    end

    task automatic chk(bit ok, string req, string what, logic [W-1:0] act, logic [W-1:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // reference behaviour written from the requirements
    function automatic exp_t model(bit op, logic [W-1:0] x, int lx, int px,
                                   logic [W-1:0] y, int ly, string tag);
        exp_t r;
        int total, st, av;
        r.d = '0; r.e = 0; r.tag = tag;
        if (lx > W) lx = W;           // R9
        if (ly > W) ly = W;
        if (!op) begin
            total = lx + ly;
            r.o = (total > W);
            r.l = LW'(r.o ? W : total);
            for (int i = 0; i < W; i++) begin
                if (i < ly) r.d[i] = y[i];
                else if (i - ly < lx) r.d[i] = x[i - ly];
            end
            r.p = LW'(px);
        end else begin
            st = (px > W) ? W : px;
            av = W - st;
            r.o = (ly > av);
            r.l = LW'(r.o ? av : ly);
            for (int i = 0; i < int'(r.l); i++)
                if (st + i < lx) r.d[i] = x[st + i];
            r.p = LW'(st + int'(r.l));
        end
        return r;
    endfunction

    task automatic send(bit op, logic [W-1:0] x, int lx, int px,
                        logic [W-1:0] y, int ly, string tag);
        exp_t ex;
        @(posedge clk); #1;
        in_valid = 1'b1; in_op = op;
        x_data = x; x_len = LW'(lx); x_ptr = LW'(px);
        y_data = y; y_len = LW'(ly);
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        ex = model(op, x, lx, px, y, ly, tag);
        ex.e = edge_cnt + 1;
        sb.push_back(ex);
    endtask

    task automatic idle();
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    // monitor: due-edge validity, stall holding, field comparison on transfer
    logic          prev_stall = 1'b0;
    logic [W-1:0]  prev_d;
    logic [LW-1:0] prev_l, prev_p;
    logic          prev_o;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit ev;
            ev = (sb.size() > 0) && (edge_cnt >= sb[0].e);
            chk(out_valid == ev, "R10", "out_valid vs due edge", W'(out_valid), W'(ev));
            if (prev_stall)
                chk(out_data == prev_d && out_len == prev_l && out_ovf == prev_o &&
                    out_src_ptr == prev_p, "R10", "held output", out_data, prev_d);
            if (out_valid && !out_ready)
                chk(!in_ready, "R10", "in_ready during stall", W'(in_ready), '0);
            if (out_valid && out_ready && ev) begin
                exp_t h;
                h = sb.pop_front();
                chk(out_data == h.d, h.tag, "data", out_data, h.d);
                chk(out_len == h.l, h.tag, "len", W'(out_len), W'(h.l));
                chk(out_ovf == h.o, h.tag, "ovf", W'(out_ovf), W'(h.o));
                chk(out_src_ptr == h.p, "R7", "src ptr", W'(out_src_ptr), W'(h.p));
            end
            prev_stall = out_valid && !out_ready;
            prev_d = out_data; prev_l = out_len; prev_o = out_ovf; prev_p = out_src_ptr;
        end
    end

    task automatic finish_run();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!out_valid, "R1", "out_valid in reset", W'(out_valid), '0);
        chk(in_ready, "R1", "in_ready in reset", W'(in_ready), W'(1));
        @(posedge clk); #1; rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid, "R1", "out_valid after reset", W'(out_valid), '0);

        // R3: 12-bit X joined with 8-bit Y gives 20 bits
        send(0, 64'hABC, 12, 0, 64'h5D, 8, "R3");
        // R2: garbage above the lengths is ignored
        send(0, 64'hFFFF_FFFF_FFFF_FABC, 12, 3, 64'hFFFF_FF5D, 8, "R2");
        send(0, 64'h1, 1, 0, 64'h0, 0, "R2");
        send(0, 64'h0, 0, 0, 64'h3F, 6, "R2");
        // R4: overflow and exact fit
        send(0, 64'h12_3456_789A, 40, 0, 64'h3FFF_FFFF, 30, "R4");
        send(0, 64'hDEAD_BEEF_0123_4567, 64, 0, 64'h0, 0, "R4");
        send(0, 64'hFFFF_FFFF, 32, 0, 64'h8000_0001, 32, "R4");
        // R9: length descriptor above the width
        send(0, 64'hCAFE_F00D_1234_5678, 100, 0, 64'h0, 0, "R9");
        send(1, 64'hCAFE_F00D_1234_5678, 64, 8, 64'h0, 120, "R9");
        // R5: in-range slices
        send(1, 64'h0000_0000_0000_0AB0, 16, 4, 64'h0, 8, "R5");
        send(1, 64'hFEDC_BA98_7654_3210, 64, 32, 64'h0, 16, "R5");
        send(1, 64'hFEDC_BA98_7654_3210, 20, 12, 64'h0, 16, "R5");
        send(1, 64'hFEDC_BA98_7654_3210, 64, 5, 64'h0, 0, "R5");
        // R6: clipped slices
        send(1, 64'hF000_0000_0000_0000, 64, 60, 64'h0, 10, "R6");
        send(1, 64'hFFFF_FFFF_FFFF_FFFF, 64, 64, 64'h0, 5, "R6");
        send(1, 64'hFFFF_FFFF_FFFF_FFFF, 64, 90, 64'h0, 1, "R6");
        idle();
        repeat (4) @(posedge clk);

        // R10: back-to-back traffic under backpressure
        rmode = 1;
        for (int k = 0; k < 24; k++) begin
            logic [W-1:0] a, b;
            a = {32'(k * 32'h9E37_79B9), 32'(k * 32'h85EB_CA6B)};
            b = ~a ^ 64'(k);
            send(k[0], a, (k * 7) % 70, (k * 11) % 70, b, (k * 13) % 70,
                 k[0] ? "R5" : "R2");
        end
        idle();
        rmode = 0;
        for (int t = 0; t < 200 && sb.size() > 0; t++) @(posedge clk);
        @(negedge clk);
        chk(sb.size() == 0, "R10", "all results drained", W'(sb.size()), '0);
        finish_run();
    end
endmodule